// File: doc/BRIEF.md
# Associative Cell String with Marked-Region Shifting

This block is a one-dimensional string of identical storage cells. Each cell holds one symbol, a match flag and a control (active) flag. A single command code and a single pattern symbol go to every cell in the same cycle, and every cell carries out that command in parallel. The command set covers four operations. A search compares every stored symbol with the pattern. A mark turns every matching cell active in one step, so strings in widely separated parts of the array can be marked together. A propagate step moves a match one cell to the right when the next stored symbol equals the new pattern, which lets a multi-symbol string be found one symbol per command. A region shift moves the symbols of all active cells one place left or right at once, which opens or closes a gap.

A load port writes one cell's symbol and a read port returns any cell's symbol. Together they set the string up and inspect it. The per-cell match flags, the per-cell active flags and their wired-OR summary are visible at all times.

Top module: `assoc_string`

## Requirements
- R1: After reset, every stored symbol is 0x00, every match flag and every active flag is clear, and any_match is low.
- R2: While load_en is high, the symbol in cell load_idx becomes load_data at the clock edge. read_data always shows the symbol of cell read_idx, combinationally.
- R3: Command code 1 (search) sets each cell's match flag to whether its stored symbol equals pattern. It replaces the earlier match flags and leaves the active flags unchanged.
- R4: any_match is the OR of all match flags. It is valid in the cycle after a search and is low after a clear.
- R5: Command code 2 (mark) sets the active flag of every cell whose match flag is set. It keeps the active flags that are already set and leaves the match flags unchanged.
- R6: Command code 3 (propagate) sets the match flag of cell i+1 exactly when cell i's match flag was set and cell i+1 holds pattern. Every cell so matched also becomes active. Cell 0's match flag clears, and active flags are never cleared by this command.
- R7: Command code 4 (shift right) gives each active cell the symbol of its left neighbour if that neighbour is active, and 0x00 otherwise. Inactive cells keep their symbols.
- R8: Command code 5 (shift left) gives each active cell the symbol of its right neighbour if that neighbour is active, and 0x00 otherwise. Inactive cells keep their symbols.
- R9: Command code 6 (clear) clears every match flag and every active flag. It leaves the symbols unchanged.
- R10: Command code 7 (write) stores pattern into every active cell and leaves the inactive cells unchanged.
- R11: Command code 0 (idle) changes no symbol and no flag, whatever the pattern is. No command other than a shift or a write changes a symbol.
- R12: When a load and a command that changes symbols hit the same cell in the same cycle, the loaded value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd | input | 3 | Command code broadcast to all cells |
| pattern | input | 8 | Pattern symbol broadcast to all cells |
| load_en | input | 1 | Write one cell's symbol |
| load_idx | input | 5 | Cell to write |
| load_data | input | 8 | Symbol to write |
| read_idx | input | 5 | Cell to read |
| read_data | output | 8 | Symbol of cell read_idx |
| match_vec | output | 32 | Match flag of each cell, bit i for cell i |
| active_vec | output | 32 | Active flag of each cell, bit i for cell i |
| any_match | output | 1 | OR of all match flags |

## Verification
The bench plants the same three-symbol string at two distant positions. It adds a lone copy of the first symbol in the last cell, with the second symbol in cell 0, so a propagate that wraps around the end or forgets its left neighbour sets a flag that should stay clear. Shifts run on several marked regions at once: a design that fills the region's leading cell from an inactive neighbour, or that moves inactive cells, leaves a wrong symbol at a region boundary. A write to active cells is combined with a same-cycle load of one of those cells, which catches a wrong precedence. A second search catches match flags that build up instead of being replaced.

// File: rtl/assoc_string_pkg.sv
package assoc_string_pkg;

   typedef enum logic [2:0] {
      OP_IDLE   = 3'd0,
      OP_SEARCH = 3'd1,
      OP_MARK   = 3'd2,
      OP_PROP   = 3'd3,
      OP_SHR    = 3'd4,
      OP_SHL    = 3'd5,
      OP_CLEAR  = 3'd6,
      OP_WRITE  = 3'd7
   } op_e;

endpackage

// File: rtl/assoc_cell.sv
module assoc_cell
   import assoc_string_pkg::*;
#(
   parameter int unsigned SYM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  op_e              op,
   input  logic [SYM_W-1:0] pattern,
   input  logic             load_hit,
   input  logic [SYM_W-1:0] load_data,
   input  logic [SYM_W-1:0] lft_sym,
   input  logic             lft_act,
   input  logic             lft_match,
   input  logic [SYM_W-1:0] rgt_sym,
   input  logic             rgt_act,
   output logic [SYM_W-1:0] sym_q,
   output logic             match_q,
   output logic             act_q
);

   logic [SYM_W-1:0] sym_d;
   logic             match_d;
   logic             act_d;
   logic             hit;

   assign hit = (sym_q == pattern);

   always_comb begin
      sym_d = sym_q;
      unique case (op)
         OP_SHR:   if (act_q) sym_d = lft_act ? lft_sym : '0;
         OP_SHL:   if (act_q) sym_d = rgt_act ? rgt_sym : '0;
         OP_WRITE: if (act_q) sym_d = pattern;
         default:  sym_d = sym_q;
      endcase
      if (load_hit) sym_d = load_data;
   end

   always_comb begin
      match_d = match_q;
      act_d   = act_q;
      unique case (op)
         OP_SEARCH: match_d = hit;
         OP_MARK:   act_d   = act_q | match_q;
         OP_PROP: begin
            match_d = lft_match & hit;
            act_d   = act_q | (lft_match & hit);
         end
         OP_CLEAR: begin
            match_d = 1'b0;
            act_d   = 1'b0;
         end
         default: begin
            match_d = match_q;
            act_d   = act_q;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_q   <= '0;
         match_q <= 1'b0;
         act_q   <= 1'b0;
      end else begin
         sym_q   <= sym_d;
         match_q <= match_d;
         act_q   <= act_d;
      end
   end

   assert_search_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SEARCH) |=> (match_q == ($past(sym_q) == $past(pattern))));

   assert_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_MARK && match_q) |=> (act_q && match_q));

   assert_prop_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_PROP && !lft_match) |=> !match_q);

   assert_shift_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((op == OP_SHR || op == OP_SHL) && !act_q && !load_hit) |=> $stable(sym_q));

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CLEAR) |=> (!match_q && !act_q));

   assert_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WRITE && act_q && !load_hit) |=> (sym_q == $past(pattern)));

   assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_IDLE && !load_hit) |=> ($stable(sym_q) && $stable(match_q) && $stable(act_q)));

   assert_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
      load_hit |=> (sym_q == $past(load_data)));

endmodule

// File: rtl/assoc_or_reduce.sv
module assoc_or_reduce #(
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned GROUP   = 8,
   parameter bit          GROUPED = 1'b1
) (
   input  logic [WIDTH-1:0] vec,
   output logic             any
);

   localparam int unsigned NGRP = (WIDTH + GROUP - 1) / GROUP;
   localparam int unsigned PADW = NGRP * GROUP;

   if (GROUP < 1) begin : g_bad_group
      $error("assoc_or_reduce: GROUP must be at least 1");
   end

   if (GROUPED) begin : g_grouped
      logic [PADW-1:0] padded;
      logic [NGRP-1:0] part;
      assign padded = PADW'(vec);
      for (genvar g = 0; g < NGRP; g++) begin : g_part
         assign part[g] = |padded[g*GROUP +: GROUP];
      end
      assign any = |part;
   end else begin : g_flat
      assign any = |vec;
   end

endmodule

// File: rtl/assoc_string.sv
module assoc_string
   import assoc_string_pkg::*;
#(
   parameter int unsigned NCELL   = 32,
   parameter int unsigned SYM_W   = 8,
   parameter bit          GROUPED = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [2:0]               cmd,
   input  logic [SYM_W-1:0]         pattern,
   input  logic                     load_en,
   input  logic [$clog2(NCELL)-1:0] load_idx,
   input  logic [SYM_W-1:0]         load_data,
   input  logic [$clog2(NCELL)-1:0] read_idx,
   output logic [SYM_W-1:0]         read_data,
   output logic [NCELL-1:0]         match_vec,
   output logic [NCELL-1:0]         active_vec,
   output logic                     any_match
);

   localparam int unsigned IDX_W = $clog2(NCELL);

   if (NCELL < 2) begin : g_bad_ncell
      $error("assoc_string: NCELL must be at least 2");
   end
   if (SYM_W < 1) begin : g_bad_symw
      $error("assoc_string: SYM_W must be at least 1");
   end

   op_e              op;
   logic [SYM_W-1:0] sym   [NCELL];
   logic [SYM_W-1:0] lsym  [NCELL];
   logic [SYM_W-1:0] rsym  [NCELL];
   logic [NCELL-1:0] lact;
   logic [NCELL-1:0] ract;
   logic [NCELL-1:0] lmatch;

   assign op = op_e'(cmd);

   for (genvar i = 0; i < NCELL; i++) begin : g_cell
      if (i == 0) begin : g_left_edge
         assign lsym[i]   = '0;
         assign lact[i]   = 1'b0;
         assign lmatch[i] = 1'b0;
      end else begin : g_left_link
         assign lsym[i]   = sym[i-1];
         assign lact[i]   = active_vec[i-1];
         assign lmatch[i] = match_vec[i-1];
      end
      if (i == NCELL - 1) begin : g_right_edge
         assign rsym[i] = '0;
         assign ract[i] = 1'b0;
      end else begin : g_right_link
         assign rsym[i] = sym[i+1];
         assign ract[i] = active_vec[i+1];
      end

      assoc_cell #(.SYM_W(SYM_W)) i_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .op        (op),
         .pattern   (pattern),
         .load_hit  (load_en && (load_idx == IDX_W'(i))),
         .load_data (load_data),
         .lft_sym   (lsym[i]),
         .lft_act   (lact[i]),
         .lft_match (lmatch[i]),
         .rgt_sym   (rsym[i]),
         .rgt_act   (ract[i]),
         .sym_q     (sym[i]),
         .match_q   (match_vec[i]),
         .act_q     (active_vec[i])
      );
   end

   assign read_data = sym[read_idx];

   assoc_or_reduce #(
      .WIDTH   (NCELL),
      .GROUP   (8),
      .GROUPED (GROUPED)
   ) i_any (
      .vec (match_vec),
      .any (any_match)
   );

   assert_any_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CLEAR) |=> !any_match);

   assert_any_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SEARCH) |=> (any_match == ($countones(match_vec) != 0)));

   assert_reset_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (match_vec == '0 && active_vec == '0));

endmodule

// File: tb/test_assoc_string.sv
module test_assoc_string;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd = 3'd0;
   logic [7:0]  pattern = 8'h00;
   logic        load_en = 1'b0;
   logic [4:0]  load_idx = 5'd0;
   logic [7:0]  load_data = 8'h00;
   logic [4:0]  read_idx = 5'd0;
   logic [7:0]  read_data;
   logic [31:0] match_vec;
   logic [31:0] active_vec;
   logic        any_match;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   assoc_string i_assoc_string (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .pattern(pattern),
      .load_en(load_en), .load_idx(load_idx), .load_data(load_data),
      .read_idx(read_idx), .read_data(read_data),
      .match_vec(match_vec), .active_vec(active_vec), .any_match(any_match)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic op(logic [2:0] c, logic [7:0] p);
      @(negedge clk);
      cmd = c; pattern = p;
      @(negedge clk);
      cmd = 3'd0;
   endtask

   task automatic load(int idx, logic [7:0] d);
      @(negedge clk);
      load_en = 1'b1; load_idx = 5'(idx); load_data = d;
      @(negedge clk);
      load_en = 1'b0;
   endtask

   task automatic chk_sym(string req, int idx, logic [7:0] exp);
      read_idx = 5'(idx);
      #1;
      chk(req, {24'h0, read_data}, {24'h0, exp});
   endtask

   function automatic logic [31:0] bits(int a, int b = -1, int c = -1, int d = -1,
                                         int e = -1, int f = -1, int g = -1, int h = -1);
      logic [31:0] v = '0;
      if (a >= 0) v[a] = 1'b1;
      if (b >= 0) v[b] = 1'b1;
      if (c >= 0) v[c] = 1'b1;
      if (d >= 0) v[d] = 1'b1;
      if (e >= 0) v[e] = 1'b1;
      if (f >= 0) v[f] = 1'b1;
      if (g >= 0) v[g] = 1'b1;
      if (h >= 0) v[h] = 1'b1;
      return v;
   endfunction

   task automatic t_reset();
      chk("R1 match", match_vec, 32'h0);
      chk("R1 active", active_vec, 32'h0);
      chk("R1 any", {31'h0, any_match}, 32'h0);
      chk_sym("R1 symbol", 5, 8'h00);
   endtask

   task automatic t_load();
      for (int i = 0; i < 32; i++) load(i, 8'(8'h10 + i));
      load(0, 8'h62);
      load(3, 8'h61); load(4, 8'h62); load(5, 8'h63);
      load(20, 8'h61); load(21, 8'h62); load(22, 8'h63);
      load(27, 8'h61); load(31, 8'h61);
      chk_sym("R2 read 4", 4, 8'h62);
      chk_sym("R2 read 10", 10, 8'h1A);
      chk_sym("R2 read 0", 0, 8'h62);
   endtask

   task automatic t_search();
      op(3'd1, 8'h61);
      chk("R3 search a", match_vec, bits(3, 20, 27, 31));
      chk("R4 any high", {31'h0, any_match}, 32'h1);
      chk("R3 active kept", active_vec, 32'h0);
      op(3'd1, 8'h62);
      chk("R3 search b replaces", match_vec, bits(0, 4, 21));
      op(3'd1, 8'hFF);
      chk("R4 any low", {31'h0, any_match}, 32'h0);
   endtask

   task automatic t_chain();
      op(3'd1, 8'h61);
      op(3'd2, 8'h00);
      chk("R5 mark active", active_vec, bits(3, 20, 27, 31));
      chk("R5 match kept", match_vec, bits(3, 20, 27, 31));
      op(3'd3, 8'h62);
      chk("R6 propagate b", match_vec, bits(4, 21));
      chk("R6 active b", active_vec, bits(3, 4, 20, 21, 27, 31));
      op(3'd3, 8'h63);
      chk("R6 propagate c", match_vec, bits(5, 22));
      chk("R6 active c", active_vec, bits(3, 4, 5, 20, 21, 22, 27, 31));
   endtask

   task automatic t_shift();
      op(3'd4, 8'h00);
      chk_sym("R7 lead blank", 3, 8'h00);
      chk_sym("R7 moved a", 4, 8'h61);
      chk_sym("R7 moved b", 5, 8'h62);
      chk_sym("R7 far region", 21, 8'h61);
      chk_sym("R7 single", 27, 8'h00);
      chk_sym("R11 inactive kept", 6, 8'h16);
      chk_sym("R11 inactive left", 2, 8'h12);
      op(3'd5, 8'h00);
      chk_sym("R8 left a", 3, 8'h61);
      chk_sym("R8 left b", 4, 8'h62);
      chk_sym("R8 tail blank", 5, 8'h00);
      chk_sym("R8 far region", 22, 8'h00);
      chk_sym("R11 inactive right", 6, 8'h16);
   endtask

   task automatic t_write_idle();
      op(3'd7, 8'h77);
      chk_sym("R10 active written", 3, 8'h77);
      chk_sym("R10 far written", 27, 8'h77);
      chk_sym("R10 inactive kept", 10, 8'h1A);
      op(3'd0, 8'h1A);
      chk("R11 idle match", match_vec, bits(5, 22));
      chk("R11 idle active", active_vec, bits(3, 4, 5, 20, 21, 22, 27, 31));
      chk_sym("R11 idle symbol", 3, 8'h77);
   endtask

   task automatic t_clear();
      op(3'd6, 8'h00);
      chk("R9 match clear", match_vec, 32'h0);
      chk("R9 active clear", active_vec, 32'h0);
      chk("R4 any after clear", {31'h0, any_match}, 32'h0);
      chk_sym("R9 symbol kept", 4, 8'h77);
   endtask

   task automatic t_priority();
      op(3'd1, 8'h1A);
      op(3'd2, 8'h00);
      chk("R12 setup", active_vec, bits(10));
      @(negedge clk);
      cmd = 3'd7; pattern = 8'h99;
      load_en = 1'b1; load_idx = 5'd10; load_data = 8'h55;
      @(negedge clk);
      cmd = 3'd0; load_en = 1'b0;
      chk_sym("R12 load wins", 10, 8'h55);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_load();
      t_search();
      t_chain();
      t_shift();
      t_write_idle();
      t_clear();
      t_priority();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule